// File: doc/BRIEF.md
# Video Field Capture Write Sequencer

This block sits between a video decoder and two external FIFO memories. It runs on the decoder's luma sample clock (13.5 MHz in the intended system) and takes one 8-bit luma sample per cycle. Four decoder timing flags decide which samples are stored: horizontal sync, vertical blanking, active video and field identity. A sample is stored only when it lies inside the picture area of a field chosen for capture. Each stored field starts with a write-pointer reset of the FIFO that holds it.

In dual-field mode, fields with identity 0 go to FIFO A and fields with identity 1 go to FIFO B. In single-field mode only identity-0 fields are stored, in FIFO A. Each field stores at most 188 lines.

A small playback controller on the same clock resets the read pointer of the chosen FIFO at the start of every output field and selects the FIFO to read. In single-field mode both output fields read FIFO A, so one stored field fills a whole frame.

Top module: `field_capture_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, every write enable, write reset and read reset is low, `rd_sel_o` is 0 (FIFO A) and `wr_data_o` is 0.
- R2: A write enable is high in cycle k+1 only if in cycle k `active_i` was 1, `vblank_i` was 0, capture was enabled and `vblank_i` did not fall. `wr_data_o` in cycle k+1 is the `luma_i` of cycle k.
- R3: When `vblank_i` goes from 1 to 0 in cycle k and the field is to be captured, the target FIFO's write reset is high for exactly cycle k+1, and no write takes place in that cycle.
- R4: `field_i` is sampled in the cycle `vblank_i` falls. Value 0 makes FIFO A (`wr_en_a_o`, `wr_rst_a_o`) the target for the whole field, and value 1 makes FIFO B the target. The two write enables are never high together.
- R5: When `single_i` is 1 at the falling edge of `vblank_i`, a field with `field_i` = 1 causes no write reset and no write to either FIFO for that field.
- R6: A line counts as stored at the next rising edge of `hsync_i` after at least one write. Once 188 lines of a field are stored, no more writes occur until the next falling edge of `vblank_i`, even while `active_i` stays high.
- R7: After reset, nothing is written until the first falling edge of `vblank_i`.
- R8: A one-cycle `ofld_start_i` in cycle k gives a one-cycle read reset in cycle k+1 and sets `rd_sel_o` (0 = A, 1 = B), which then holds. The selection is B only when `ofld_id_i` = 1 and `single_i` = 0; otherwise it is A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Luma sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| luma_i | input | 8 | Luma sample from the decoder |
| hsync_i | input | 1 | Decoder horizontal sync, active high |
| vblank_i | input | 1 | Decoder vertical blanking, active high |
| active_i | input | 1 | Decoder active-video flag |
| field_i | input | 1 | Decoder field identity |
| single_i | input | 1 | 1 = single-field capture and playback |
| ofld_start_i | input | 1 | One-cycle pulse at the start of an output field |
| ofld_id_i | input | 1 | Identity of the output field being started |
| wr_data_o | output | 8 | Data to the FIFO write ports |
| wr_en_a_o | output | 1 | FIFO A write enable |
| wr_en_b_o | output | 1 | FIFO B write enable |
| wr_rst_a_o | output | 1 | FIFO A write-pointer reset |
| wr_rst_b_o | output | 1 | FIFO B write-pointer reset |
| rd_rst_a_o | output | 1 | FIFO A read-pointer reset |
| rd_rst_b_o | output | 1 | FIFO B read-pointer reset |
| rd_sel_o | output | 1 | Playback FIFO select, 0 = A, 1 = B |

## Verification
Lines of active video are first sent before any blanking has been seen, which separates correct start-up gating from writing at once. Full fields of 195 active lines in both identities then show whether steering goes to the right FIFO and whether the 188-line limit cuts off the extra lines. Active pulses inside blanking check that blanking gates writes. Single-field runs with both identities show that field 1 leaves both FIFOs untouched and that playback stays on FIFO A. A short 100-line field after a full one shows that the write reset discards the old contents instead of appending to them.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic {
        FIFO_A = 1'b0,
        FIFO_B = 1'b1
    } fifo_sel_e;

    typedef struct packed {
        logic      rst_a;
        logic      rst_b;
        fifo_sel_e sel;
    } rd_ctrl_t;

endpackage

// File: rtl/fcs_edge_detect.sv
module fcs_edge_detect #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = !sig_i && prev_q;
        end else begin : g_rise
            assign edge_o = sig_i && !prev_q;
        end
    endgenerate
endmodule

// File: rtl/fcs_write_ctrl.sv
module fcs_write_ctrl #(
    parameter int DATA_W = 8,
    parameter int LINES  = 188
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] luma_i,
    input  logic              active_i,
    input  logic              vblank_i,
    input  logic              field_i,
    input  logic              single_i,
    input  logic              hs_rise_i,
    input  logic              vb_fall_i,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_en_a_o,
    output logic              wr_en_b_o,
    output logic              wr_rst_a_o,
    output logic              wr_rst_b_o
);
    import fcs_pkg::*;

    localparam int LCNT_W = $clog2(LINES + 1);
    localparam logic [LCNT_W-1:0] LINES_C = LCNT_W'(LINES);

    typedef struct packed {
        logic              cap_en;
        fifo_sel_e         tgt;
        logic              single;
        logic [LCNT_W-1:0] lines;
        logic              line_wr;
        logic              wen_a;
        logic              wen_b;
        logic              wrst_a;
        logic              wrst_b;
        logic [DATA_W-1:0] data;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic      take_field;
    logic      do_write;

    always_comb begin
        s_d        = s_q;
        s_d.wen_a  = 1'b0;
        s_d.wen_b  = 1'b0;
        s_d.wrst_a = 1'b0;
        s_d.wrst_b = 1'b0;
        s_d.data   = luma_i;
        take_field = !single_i || !field_i;
        do_write   = 1'b0;

        if (vb_fall_i) begin
            // field boundary: latch target and mode, restart line count
            s_d.cap_en  = take_field;
            s_d.tgt     = field_i ? FIFO_B : FIFO_A;
            s_d.single  = single_i;
            s_d.lines   = '0;
            s_d.line_wr = 1'b0;
            s_d.wrst_a  = take_field && !field_i;
            s_d.wrst_b  = take_field && field_i;
        end else begin
            do_write = s_q.cap_en && active_i && !vblank_i
                       && (s_q.lines < LINES_C);
            if (hs_rise_i) begin
                if (s_q.line_wr) s_d.lines = s_q.lines + 1'b1;
                s_d.line_wr = do_write;
            end else begin
                s_d.line_wr = s_q.line_wr || do_write;
            end
            s_d.wen_a = do_write && (s_q.tgt == FIFO_A);
            s_d.wen_b = do_write && (s_q.tgt == FIFO_B);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_data_o  = s_q.data;
    assign wr_en_a_o  = s_q.wen_a;
    assign wr_en_b_o  = s_q.wen_b;
    assign wr_rst_a_o = s_q.wrst_a;
    assign wr_rst_b_o = s_q.wrst_b;

    AST_WEN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.wen_a && s_q.wen_b)); // R4
    AST_WR_IN_PICTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wen_a || s_q.wen_b) |-> $past(active_i && !vblank_i)); // R2
    AST_RST_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wrst_a || s_q.wrst_b) |-> $past(!vblank_i)); // R3
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wrst_a || s_q.wrst_b) |=> !(s_q.wrst_a || s_q.wrst_b)); // R3
    AST_LINE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lines <= LINES_C); // R6
    AST_SINGLE_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.single |-> !(s_q.wen_b || s_q.wrst_b)); // R5
endmodule

// File: rtl/fcs_read_ctrl.sv
module fcs_read_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic id_i,
    input  logic single_i,
    output logic rd_rst_a_o,
    output logic rd_rst_b_o,
    output logic rd_sel_o
);
    import fcs_pkg::*;

    rd_ctrl_t r_d, r_q;
    logic     use_b;

    always_comb begin
        r_d       = r_q;
        r_d.rst_a = 1'b0;
        r_d.rst_b = 1'b0;
        use_b     = id_i && !single_i;
        if (start_i) begin
            r_d.rst_a = !use_b;
            r_d.rst_b = use_b;
            r_d.sel   = use_b ? FIFO_B : FIFO_A;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.rst_a <= 1'b0;
            r_q.rst_b <= 1'b0;
            r_q.sel   <= FIFO_A;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_rst_a_o = r_q.rst_a;
    assign rd_rst_b_o = r_q.rst_b;
    assign rd_sel_o   = r_q.sel;

    AST_RD_RST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.rst_a, r_q.rst_b})); // R8
    AST_RD_SINGLE_A: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rst_b |-> $past(!single_i && start_i)); // R8
    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.rst_a || r_q.rst_b) |-> $stable(r_q.sel)); // R8
endmodule

// File: rtl/field_capture_seq.sv
module field_capture_seq #(
    parameter int DATA_W = 8,
    parameter int LINES  = 188
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] luma_i,
    input  logic              hsync_i,
    input  logic              vblank_i,
    input  logic              active_i,
    input  logic              field_i,
    input  logic              single_i,
    input  logic              ofld_start_i,
    input  logic              ofld_id_i,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_en_a_o,
    output logic              wr_en_b_o,
    output logic              wr_rst_a_o,
    output logic              wr_rst_b_o,
    output logic              rd_rst_a_o,
    output logic              rd_rst_b_o,
    output logic              rd_sel_o
);
    logic hs_rise;
    logic vb_fall;

    fcs_edge_detect #(.FALLING(1'b0)) i_hs_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (hsync_i),
        .edge_o (hs_rise)
    );

    fcs_edge_detect #(.FALLING(1'b1)) i_vb_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (vblank_i),
        .edge_o (vb_fall)
    );

    fcs_write_ctrl #(.DATA_W(DATA_W), .LINES(LINES)) i_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .luma_i     (luma_i),
        .active_i   (active_i),
        .vblank_i   (vblank_i),
        .field_i    (field_i),
        .single_i   (single_i),
        .hs_rise_i  (hs_rise),
        .vb_fall_i  (vb_fall),
        .wr_data_o  (wr_data_o),
        .wr_en_a_o  (wr_en_a_o),
        .wr_en_b_o  (wr_en_b_o),
        .wr_rst_a_o (wr_rst_a_o),
        .wr_rst_b_o (wr_rst_b_o)
    );

    fcs_read_ctrl i_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (ofld_start_i),
        .id_i       (ofld_id_i),
        .single_i   (single_i),
        .rd_rst_a_o (rd_rst_a_o),
        .rd_rst_b_o (rd_rst_b_o),
        .rd_sel_o   (rd_sel_o)
    );

    AST_NO_WRITE_DURING_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rst_a_o || wr_rst_b_o) |-> !(wr_en_a_o || wr_en_b_o)); // R3
endmodule

// File: tb/test_field_capture_seq.sv
module test_field_capture_seq;
    localparam int LINES   = 188;
    localparam int SAMPLES = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] luma = 8'h00;
    logic       hsync = 1'b0, vblank = 1'b0, active = 1'b0, field = 1'b0;
    logic       single = 1'b0, ofld_start = 1'b0, ofld_id = 1'b0;
    logic [7:0] wr_data;
    logic       wen_a, wen_b, wrst_a, wrst_b, rrst_a, rrst_b, rsel;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    field_capture_seq #(.DATA_W(8), .LINES(LINES)) i_field_capture_seq (
        .clk(clk), .rst_n(rst_n), .luma_i(luma), .hsync_i(hsync),
        .vblank_i(vblank), .active_i(active), .field_i(field),
        .single_i(single), .ofld_start_i(ofld_start), .ofld_id_i(ofld_id),
        .wr_data_o(wr_data), .wr_en_a_o(wen_a), .wr_en_b_o(wen_b),
        .wr_rst_a_o(wrst_a), .wr_rst_b_o(wrst_b), .rd_rst_a_o(rrst_a),
        .rd_rst_b_o(rrst_b), .rd_sel_o(rsel)
    );

    // behavioural reference: what each output must show after this edge
    int   m_vb_prev = 0, m_hs_prev = 0;
    bit   m_capturing = 0;
    int   m_target = 0, m_stored = 0, m_line_used = 0;
    logic e_wa = 0, e_wb = 0, e_ra = 0, e_rb = 0, e_qa = 0, e_qb = 0, e_sel = 0;
    logic [7:0] e_data = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_vb_prev = 0; m_hs_prev = 0; m_capturing = 0; m_target = 0;
            m_stored = 0; m_line_used = 0;
            {e_wa, e_wb, e_ra, e_rb, e_qa, e_qb, e_sel} = '0;
            e_data = 0;
        end else begin
            e_wa = 0; e_wb = 0; e_ra = 0; e_rb = 0; e_qa = 0; e_qb = 0;
            e_data = luma;
            if (m_vb_prev == 1 && vblank == 0) begin
                m_capturing = !(single && field);
                m_target = field;
                m_stored = 0;
                m_line_used = 0;
                if (m_capturing) begin
                    if (field) e_rb = 1; else e_ra = 1;
                end
            end else begin
                bit w;
                w = m_capturing && active && !vblank && (m_stored < LINES);
                if (hsync && m_hs_prev == 0) begin
                    if (m_line_used != 0) m_stored++;
                    m_line_used = w;
                end else if (w) begin
                    m_line_used = 1;
                end
                if (w) begin
                    if (m_target == 1) e_wb = 1; else e_wa = 1;
                end
            end
            m_vb_prev = vblank;
            m_hs_prev = hsync;
            if (ofld_start) begin
                bit b;
                b = ofld_id && !single;
                e_sel = b;
                if (b) e_qb = 1; else e_qa = 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    logic [7:0] fifo_a[$];
    logic [7:0] fifo_b[$];

    // one clock: compare outputs, update FIFO models, then drive new inputs
    task automatic cyc(input logic hs, input logic vb, input logic av,
                       input logic rs, input logic rid);
        @(negedge clk);
        check("R2 R4 R5 R6 R7", "wr_en_a", wen_a, e_wa);
        check("R2 R4 R5 R6 R7", "wr_en_b", wen_b, e_wb);
        check("R3", "wr_rst_a/b", {wrst_a, wrst_b}, {e_ra, e_rb});
        check("R8", "rd_rst/sel", {rrst_a, rrst_b, rsel}, {e_qa, e_qb, e_sel});
        if (wen_a || wen_b) check("R2", "wr_data", wr_data, e_data);
        if (wrst_a) fifo_a.delete();
        if (wrst_b) fifo_b.delete();
        if (wen_a) fifo_a.push_back(wr_data);
        if (wen_b) fifo_b.push_back(wr_data);
        hsync = hs; vblank = vb; active = av; ofld_start = rs; ofld_id = rid;
        luma = luma + 8'd37;
    endtask

    task automatic line(input logic vb, input logic rs, input logic rid);
        for (int c = 0; c < 24; c++)
            cyc(c < 4, vb, (c >= 6 && c < 6 + SAMPLES), rs && c == 0, rid);
    endtask

    task automatic run_field(input logic fid, input int act_lines);
        field = fid;
        for (int l = 0; l < 4; l++) line(1'b1, l == 0, fid);
        for (int l = 0; l < act_lines; l++) line(1'b0, 1'b0, 1'b0);
        for (int t = 0; t < 3; t++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        for (int t = 0; t < 150000; t++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state held
        check("R1", "outputs in reset",
              {wen_a, wen_b, wrst_a, wrst_b, rrst_a, rrst_b, rsel, wr_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "outputs after reset",
              {wen_a, wen_b, wrst_a, wrst_b, rrst_a, rrst_b, rsel, wr_data}, 0);

        // R7: active lines before any blanking must not be stored
        for (int l = 0; l < 5; l++) line(1'b0, 1'b0, 1'b0);
        check("R7", "fifo A before first blank", fifo_a.size(), 0);
        check("R7", "fifo B before first blank", fifo_b.size(), 0);

        // R4 R6: dual mode, field 0 into A, limit at 188 lines
        run_field(1'b0, 195);
        check("R6", "fifo A lines", fifo_a.size(), LINES * SAMPLES);
        check("R4", "fifo B untouched", fifo_b.size(), 0);
        check("R8", "rd_sel after field 0", rsel, 0);

        // R4: field 1 into B
        run_field(1'b1, 195);
        check("R4", "fifo B lines", fifo_b.size(), LINES * SAMPLES);
        check("R4", "fifo A kept", fifo_a.size(), LINES * SAMPLES);
        check("R8", "rd_sel after field 1", rsel, 1);

        // R5: single mode, field 1 ignored (B refilled with marker first)
        single = 1'b1;
        fifo_b.push_back(8'hEE);
        run_field(1'b1, 60);
        check("R5", "fifo B untouched in single", fifo_b.size(), LINES * SAMPLES + 1);
        check("R5", "fifo A untouched in single", fifo_a.size(), LINES * SAMPLES);
        check("R8", "rd_sel single field 1", rsel, 0);

        // R3 R5: single mode field 0 resets and refills A
        fifo_a.push_back(8'hEE);
        run_field(1'b0, 195);
        check("R3", "fifo A reset then refilled", fifo_a.size(), LINES * SAMPLES);

        // R3 R6: short field below the limit replaces old contents
        single = 1'b0;
        run_field(1'b0, 100);
        check("R3", "short field stored", fifo_a.size(), 100 * SAMPLES);
        check("R6", "short field B kept", fifo_b.size(), LINES * SAMPLES + 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule